// File: doc/BRIEF.md
# T1 Receive Performance Error Counters

This block gathers error statistics for a T1 receive path. It keeps three running counters. The line counter counts bipolar violations and excessive-zero events. The path counter counts path errors, and its source depends on the framing mode. The out-of-sync counter counts multiframes that pass while the receive synchronizer has lost alignment. The line decoder and the framer drive the inputs as single-cycle strobes. A framing-mode select and a synchronizer state level complete the inputs.

A one-second tick arrives from a system timer. On that tick all three running totals are copied together into hold registers that software can read, and the running counters restart from zero. A one-cycle update flag marks the moment the held values change, so that a status bit can be set from it. The running counters stop at their all-ones value and do not wrap. An error that arrives in the same cycle as the tick is counted in the new interval.

Top module: `t1_perf_counters`

## Requirements
- R1: While reset is asserted and until the first tick, all three held counts are zero and `upd_o` is low.
- R2: Each `bpv_stb_i` and each `exz_stb_i` pulse adds one to the line count. When both are high in the same cycle, the line count rises by two.
- R3: With `esf_mode_i` = 1 (extended superframe), each `crc_err_stb_i` pulse adds one to the path count, and `ft_err_stb_i` has no effect.
- R4: With `esf_mode_i` = 0 (superframe), each `ft_err_stb_i` pulse adds one to the path count, and `crc_err_stb_i` has no effect.
- R5: A `mf_stb_i` pulse adds one to the out-of-sync count only while `oos_i` is high. A `mf_stb_i` pulse while `oos_i` is low has no effect.
- R6: A `sec_tick_i` pulse sampled at a clock edge copies the three running totals into `line_cnt_o`, `path_cnt_o` and `oos_cnt_o`, and clears the running totals, all at that same edge. `upd_o` is high for exactly the one cycle that follows that edge.
- R7: Between ticks the held outputs do not change, whatever strobes arrive.
- R8: A strobe sampled at the same edge as `sec_tick_i` is not included in the values held at that edge. It is counted in the following interval.
- R9: A running count saturates at its all-ones value. For example, the 12-bit path count stays at 4095 after 4100 errors within one interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bpv_stb_i | input | 1 | Bipolar violation strobe |
| exz_stb_i | input | 1 | Excessive-zero strobe |
| crc_err_stb_i | input | 1 | CRC6 codeword error strobe |
| ft_err_stb_i | input | 1 | Terminal framing bit error strobe |
| esf_mode_i | input | 1 | 1 = extended superframe, 0 = superframe |
| oos_i | input | 1 | Synchronizer out-of-sync level |
| mf_stb_i | input | 1 | Multiframe boundary strobe |
| sec_tick_i | input | 1 | One-second tick |
| line_cnt_o | output | LINE_W (16) | Held line code violation count |
| path_cnt_o | output | PATH_W (12) | Held path error count |
| oos_cnt_o | output | OOS_W (12) | Held out-of-sync multiframe count |
| upd_o | output | 1 | Counts-updated flag, one cycle |

## Verification
The two functions that can fall in the same cycle are the snapshot on the one-second tick and the increment from an error strobe. The bench drives a bipolar violation, a CRC error and an out-of-sync multiframe in the very cycle of the tick. It then checks that the held values carry only the totals from before that cycle, and that a second tick reports each of those strobes as a count of one. The two line sources are also driven together, and the bench checks that the line count rises by two.

// File: rtl/t1pc_pkg.sv
package t1pc_pkg;
  // Default counter widths
  localparam int unsigned LINE_W_DEF = 16;
  localparam int unsigned PATH_W_DEF = 12;
  localparam int unsigned OOS_W_DEF  = 12;
  // Number of event sources feeding the line counter
  localparam int unsigned LINE_SRCS  = 2;

  typedef enum logic {
    FRM_SF  = 1'b0,
    FRM_ESF = 1'b1
  } frm_mode_e;
endpackage

// File: rtl/t1pc_event_sel.sv
module t1pc_event_sel
  import t1pc_pkg::*;
#(
  parameter int unsigned NSRC  = LINE_SRCS,
  localparam int unsigned LINC_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]   line_evt_i,
  input  logic              crc_err_i,
  input  logic              ft_err_i,
  input  frm_mode_e         mode_i,
  input  logic              oos_i,
  input  logic              mf_i,
  output logic [LINC_W-1:0] line_inc_o,
  output logic              path_inc_o,
  output logic              oos_inc_o
);
  logic [LINC_W-1:0] part [NSRC+1];

  // Sum of the line event sources
  assign part[0] = '0;
  for (genvar g = 0; g < NSRC; g++) begin : g_line_sum
    assign part[g+1] = part[g] + LINC_W'(line_evt_i[g]);
  end
  assign line_inc_o = part[NSRC];

  // The framing mode picks the path error source
  always_comb begin
    unique case (mode_i)
      FRM_ESF: path_inc_o = crc_err_i;
      default: path_inc_o = ft_err_i;
    endcase
  end

  assign oos_inc_o = oos_i & mf_i;

  always_comb begin
    AST_LINE_INC_RANGE: assert (line_inc_o <= LINC_W'(NSRC)); // R2
  end
endmodule

// File: rtl/t1pc_sat_counter.sv
module t1pc_sat_counter #(
  parameter int unsigned W     = 12,
  parameter int unsigned INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  input  logic             snap_i,
  output logic [W-1:0]     hold_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] run_q, run_d;
  logic [W-1:0] hold_q;
  logic         hold_en;
  logic [W:0]   sum;

  // Next state of the running counter
  always_comb begin
    sum     = {1'b0, run_q} + (W+1)'(inc_i);
    hold_en = snap_i;
    if (snap_i) begin
      run_d = W'(inc_i);
    end else if (sum > {1'b0, MAX}) begin
      run_d = MAX;
    end else begin
      run_d = sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= run_q;
    end
  end

  assign hold_o = hold_q;

  AST_SNAP_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> hold_q == $past(run_q)); // R6
  AST_SNAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> run_q == W'($past(inc_i))); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(hold_q)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_i && run_q == MAX) |=> run_q == MAX); // R9
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> run_q >= $past(run_q)); // R9
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_i && inc_i == '0) |=> $stable(run_q)); // R5
endmodule

// File: rtl/t1pc_tick_ctl.sv
module t1pc_tick_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic snap_o,
  output logic upd_o
);
  logic upd_q, upd_d;

  assign snap_o = tick_i;

  always_comb begin
    upd_d = tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  assign upd_o = upd_q;

  AST_UPD_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> upd_q); // R6
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !tick_i) |=> !upd_q); // R6
endmodule

// File: rtl/t1_perf_counters.sv
module t1_perf_counters
  import t1pc_pkg::*;
#(
  parameter int unsigned LINE_W = LINE_W_DEF,
  parameter int unsigned PATH_W = PATH_W_DEF,
  parameter int unsigned OOS_W  = OOS_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bpv_stb_i,
  input  logic              exz_stb_i,
  input  logic              crc_err_stb_i,
  input  logic              ft_err_stb_i,
  input  logic              esf_mode_i,
  input  logic              oos_i,
  input  logic              mf_stb_i,
  input  logic              sec_tick_i,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [PATH_W-1:0] path_cnt_o,
  output logic [OOS_W-1:0]  oos_cnt_o,
  output logic              upd_o
);
  localparam int unsigned LINC_W = $clog2(LINE_SRCS + 1);

  logic [LINC_W-1:0] line_inc;
  logic              path_inc;
  logic              oos_inc;
  logic              snap;
  frm_mode_e         mode;

  assign mode = esf_mode_i ? FRM_ESF : FRM_SF;

  t1pc_event_sel #(.NSRC(LINE_SRCS)) u_sel (
    .line_evt_i ({exz_stb_i, bpv_stb_i}),
    .crc_err_i  (crc_err_stb_i),
    .ft_err_i   (ft_err_stb_i),
    .mode_i     (mode),
    .oos_i      (oos_i),
    .mf_i       (mf_stb_i),
    .line_inc_o (line_inc),
    .path_inc_o (path_inc),
    .oos_inc_o  (oos_inc)
  );

  t1pc_tick_ctl u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (sec_tick_i),
    .snap_o (snap),
    .upd_o  (upd_o)
  );

  t1pc_sat_counter #(.W(LINE_W), .INC_W(LINC_W)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (line_inc),
    .snap_i (snap),
    .hold_o (line_cnt_o)
  );

  t1pc_sat_counter #(.W(PATH_W), .INC_W(1)) u_path (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (path_inc),
    .snap_i (snap),
    .hold_o (path_cnt_o)
  );

  t1pc_sat_counter #(.W(OOS_W), .INC_W(1)) u_oos (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (oos_inc),
    .snap_i (snap),
    .hold_o (oos_cnt_o)
  );

  AST_OUTS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick_i |=> ($stable(line_cnt_o) && $stable(path_cnt_o) && $stable(oos_cnt_o))); // R7
  AST_ESF_SKIPS_FT: assert property (@(posedge clk) disable iff (!rst_n)
    (esf_mode_i && !crc_err_stb_i) |-> !path_inc); // R3
  AST_SF_SKIPS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!esf_mode_i && !ft_err_stb_i) |-> !path_inc); // R4
endmodule

// File: tb/sim_t1_perf_counters.sv
`timescale 1ns/1ps
module sim_t1_perf_counters;
  logic clk = 1'b0;
  logic rst_n;
  logic bpv, exz, crc, ft, esf, oos, mf, tick;
  logic [15:0] line_cnt;
  logic [11:0] path_cnt, oos_cnt;
  logic upd;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  t1_perf_counters u0 (
    .clk(clk), .rst_n(rst_n), .bpv_stb_i(bpv), .exz_stb_i(exz),
    .crc_err_stb_i(crc), .ft_err_stb_i(ft), .esf_mode_i(esf), .oos_i(oos),
    .mf_stb_i(mf), .sec_tick_i(tick), .line_cnt_o(line_cnt),
    .path_cnt_o(path_cnt), .oos_cnt_o(oos_cnt), .upd_o(upd)
  );

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle pulse on the chosen strobes (drive at negedge, clear next negedge)
  task automatic pulse(bit b, bit z, bit c, bit f, bit m);
    bpv = b; exz = z; crc = c; ft = f; mf = m;
    @(negedge clk);
    bpv = 0; exz = 0; crc = 0; ft = 0; mf = 0;
  endtask

  // tick; returns at the negedge after the snapshot edge
  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic test_reset();
    check("R1 line", line_cnt, 0);
    check("R1 path", path_cnt, 0);
    check("R1 oos", oos_cnt, 0);
    check("R1 upd", upd, 0);
  endtask

  task automatic test_line();
    do_tick(); @(negedge clk);
    for (int i = 0; i < 3; i++) pulse(1, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) pulse(0, 1, 0, 0, 0);
    pulse(1, 1, 0, 0, 0);
    check("R7 held before tick", line_cnt, 0);
    do_tick();
    check("R2 line count", line_cnt, 7);
    check("R6 upd high", upd, 1);
    @(negedge clk);
    check("R6 upd one cycle", upd, 0);
  endtask

  task automatic test_esf();
    esf = 1;
    do_tick();
    for (int i = 0; i < 5; i++) pulse(0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) pulse(0, 0, 0, 1, 0);
    do_tick();
    check("R3 esf path", path_cnt, 5);
    check("R6 line cleared", line_cnt, 0);
  endtask

  task automatic test_sf();
    esf = 0;
    do_tick();
    for (int i = 0; i < 3; i++) pulse(0, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) pulse(0, 0, 1, 0, 0);
    do_tick();
    check("R4 sf path", path_cnt, 3);
  endtask

  task automatic test_oos();
    do_tick();
    oos = 0;
    for (int i = 0; i < 4; i++) pulse(0, 0, 0, 0, 1);
    oos = 1;
    for (int i = 0; i < 6; i++) pulse(0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    oos = 0;
    do_tick();
    check("R5 oos count", oos_cnt, 6);
  endtask

  task automatic test_overlap();
    esf = 1; oos = 1;
    do_tick();
    pulse(1, 0, 1, 0, 1);
    pulse(1, 0, 1, 0, 1);
    // strobes coincide with the tick
    tick = 1; bpv = 1; crc = 1; mf = 1;
    @(negedge clk);
    tick = 0; bpv = 0; crc = 0; mf = 0; oos = 0;
    check("R8 line excludes tick-cycle", line_cnt, 2);
    check("R8 path excludes tick-cycle", path_cnt, 2);
    check("R8 oos excludes tick-cycle", oos_cnt, 2);
    do_tick();
    check("R8 line next interval", line_cnt, 1);
    check("R8 path next interval", path_cnt, 1);
    check("R8 oos next interval", oos_cnt, 1);
  endtask

  task automatic test_sat();
    esf = 1;
    do_tick();
    crc = 1;
    repeat (4100) @(negedge clk);
    crc = 0;
    check("R7 held during burst", path_cnt, 0);
    do_tick();
    check("R9 path saturates", path_cnt, 4095);
    do_tick();
    check("R6 cleared after sat", path_cnt, 0);
  endtask

  initial begin
    rst_n = 0; bpv = 0; exz = 0; crc = 0; ft = 0; esf = 0; oos = 0; mf = 0; tick = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_line();
    test_esf();
    test_sf();
    test_oos();
    test_overlap();
    test_sat();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule